// File: doc/BRIEF.md
# Binary and Packed-BCD Add/Subtract Unit

This block is the arithmetic core of an 8-bit style accumulator datapath. It adds with carry or subtracts with borrow. Each operation runs either in plain two's-complement binary or in packed BCD, where every 4-bit digit holds a value from 0 to 9. It returns the result together with negative (N), zero (Z), carry (C) and overflow (V) flags. The number of decimal digits is a parameter, and the default of two digits gives an 8-bit word.

The surrounding sequencer presents the accumulator, the operand, the incoming carry, the mode select and the add/subtract select, and pulses `valid_i` for one cycle. The arithmetic is purely combinational. Result and flags are captured on the rising clock edge where `valid_i` is high and then hold until the next strobe.

In decimal mode the flags come from different stages of the computation:
- Z comes from the plain binary sum.
- V comes from the top digit before its correction.
- N and C come from the corrected result.

Subtraction in decimal mode first replaces the operand by its nines complement and then runs the same digit-correcting adder.

Top module: `bcd_addsub`

## Requirements
- R1: While reset is asserted, and after its release until the first strobe, result and all four flags read 0.
- R2: Result and flags change only on a rising edge where `valid_i` is 1. With `valid_i` at 0 they hold their value whatever the other inputs do.
- R3: Binary add (`dec_i`=0, `sub_i`=0): the W+1-bit value {C, result} equals acc + operand + carry_in. N is result bit W-1, and Z is 1 exactly when the result is 0.
- R4: In binary mode V is 1 when acc and the effective operand share bit W-1 and the result's bit W-1 differs from acc's bit W-1.
- R5: Binary subtract (`dec_i`=0, `sub_i`=1): the effective operand is the bitwise inverse of the operand, then the R3 add is performed. So C=1 means no borrow, and V follows R4 on the inverted operand.
- R6: Decimal add (`dec_i`=1, `sub_i`=0):
  - Each digit, from the lowest up, sums acc digit + operand digit + the carry from below, where the lowest carry is carry_in.
  - If that sum exceeds 9, 6 is added.
  - The carry to the next digit is 1 when the adjusted value exceeds 15.
  - The result digit is the low 4 bits of the adjusted value, and C is the carry out of the top digit.
- R7: In decimal mode Z is 1 exactly when the low W bits of acc + effective operand + carry_in are 0.
- R8: In decimal mode N is bit W-1 of the corrected result.
- R9: In decimal mode V is 1 when acc and the effective operand share bit W-1 and bit 3 of the unadjusted top-digit sum differs from acc's bit W-1.
- R10: Decimal subtract (`dec_i`=1, `sub_i`=1): the effective operand is (all digits 9) minus the operand, modulo 2^W. It then passes through the R6 path with the same carry_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | One-cycle strobe: capture the operation on this edge |
| acc_i | input | 4*DIGITS | Accumulator operand |
| opnd_i | input | 4*DIGITS | Second operand |
| carry_i | input | 1 | Carry in (1 = no borrow for subtract) |
| dec_i | input | 1 | 1 = packed BCD mode, 0 = binary |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| result_o | output | 4*DIGITS | Registered result |
| flag_n_o | output | 1 | Registered negative flag |
| flag_z_o | output | 1 | Registered zero flag |
| flag_c_o | output | 1 | Registered carry flag |
| flag_v_o | output | 1 | Registered overflow flag |

## Verification
The bench builds the block with the default DIGITS=2, which gives an 8-bit word. At that size a few thousand random operations cover every pairing of nibble values, both carry-in values, all four mode combinations and non-BCD operand digits in decimal mode. Directed cases add digit-carry ripple, results that wrap to zero, the signed-overflow boundary and decimal borrow.

// File: rtl/bcdalu_pkg.sv
package bcdalu_pkg;
  localparam int NIB_W = 4;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/bcdalu_rst_sync.sv
module bcdalu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bcdalu_digit.sv
module bcdalu_digit (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       c_i,
  output logic [3:0] nib_o,
  output logic       c_o
);
  logic [4:0] raw;
  logic [5:0] adj;

  always_comb begin
    raw = {1'b0, a_i} + {1'b0, b_i} + {4'b0, c_i};
    adj = (raw > 5'd9) ? ({1'b0, raw} + 6'd6) : {1'b0, raw};
    // R6: carry only when the corrected digit leaves the 4-bit range
    c_o   = (adj > 6'd15);
    nib_o = adj[3:0];
  end
endmodule

// File: rtl/bcdalu_core.sv
module bcdalu_core #(
  parameter int DIGITS = 2,
  localparam int W = bcdalu_pkg::NIB_W * DIGITS
) (
  input  logic [W-1:0]        acc_i,
  input  logic [W-1:0]        opnd_i,
  input  logic                carry_i,
  input  logic                dec_i,
  input  logic                sub_i,
  output logic [W-1:0]        sum_o,
  output bcdalu_pkg::flags_t  flg_o
);
  localparam logic [W-1:0] NINES = {DIGITS{4'h9}};

  logic [W-1:0]  op_bin, op_dec, dec_sum, zsum;
  logic [W:0]    bin_sum;
  logic [DIGITS:0] cy;
  logic [4:0]    top_raw;

  assign op_bin = sub_i ? ~opnd_i : opnd_i;
  assign op_dec = sub_i ? (NINES - opnd_i) : opnd_i;

  assign cy[0] = carry_i;
  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    bcdalu_digit u_digit (
      .a_i  (acc_i[4*g +: 4]),
      .b_i  (op_dec[4*g +: 4]),
      .c_i  (cy[g]),
      .nib_o(dec_sum[4*g +: 4]),
      .c_o  (cy[g+1])
    );
  end

  always_comb begin
    bin_sum = {1'b0, acc_i} + {1'b0, op_bin} + {{W{1'b0}}, carry_i};
    zsum    = acc_i + op_dec + {{(W-1){1'b0}}, carry_i};
    top_raw = {1'b0, acc_i[W-1 -: 4]} + {1'b0, op_dec[W-1 -: 4]}
            + {4'b0, cy[DIGITS-1]};
    if (!dec_i) begin
      sum_o   = bin_sum[W-1:0];
      flg_o.c = bin_sum[W];
      flg_o.n = bin_sum[W-1];
      flg_o.z = (bin_sum[W-1:0] == '0);
      flg_o.v = (acc_i[W-1] ~^ op_bin[W-1]) & (acc_i[W-1] ^ bin_sum[W-1]);
    end else begin
      sum_o   = dec_sum;
      flg_o.c = cy[DIGITS];
      flg_o.n = dec_sum[W-1];
      flg_o.z = (zsum == '0);
      flg_o.v = (acc_i[W-1] ~^ op_dec[W-1]) & (acc_i[W-1] ^ top_raw[3]);
    end
  end
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub #(
  parameter int DIGITS = 2,
  localparam int W = bcdalu_pkg::NIB_W * DIGITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic         carry_i,
  input  logic         dec_i,
  input  logic         sub_i,
  output logic [W-1:0] result_o,
  output logic         flag_n_o,
  output logic         flag_z_o,
  output logic         flag_c_o,
  output logic         flag_v_o
);
  import bcdalu_pkg::*;

  logic         rst_sync_n;
  logic [W-1:0] sum_c, res_q, res_d;
  flags_t       flg_c, flg_q, flg_d;

  bcdalu_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  bcdalu_core #(.DIGITS(DIGITS)) u_core (
    .acc_i  (acc_i),
    .opnd_i (opnd_i),
    .carry_i(carry_i),
    .dec_i  (dec_i),
    .sub_i  (sub_i),
    .sum_o  (sum_c),
    .flg_o  (flg_c)
  );

  always_comb begin
    res_d = res_q;
    flg_d = flg_q;
    if (valid_i) begin
      res_d = sum_c;
      flg_d = flg_c;
    end
  end

  // R1: cleared asynchronously, released by the synchronised reset
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      flg_q <= '0;
    end else begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign result_o = res_q;
  assign flag_n_o = flg_q.n;
  assign flag_z_o = flg_q.z;
  assign flag_c_o = flg_q.c;
  assign flag_v_o = flg_q.v;

  logic [DIGITS-1:0] in_ok, out_ok;
  for (genvar g = 0; g < DIGITS; g++) begin : g_bcd
    assign in_ok[g]  = (acc_i[4*g +: 4] <= 4'd9) && (opnd_i[4*g +: 4] <= 4'd9);
    assign out_ok[g] = (result_o[4*g +: 4] <= 4'd9);
  end

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !valid_i |=> ($stable(result_o) && $stable({flag_n_o, flag_z_o, flag_c_o, flag_v_o})));

  // R3
  bin_add_sum_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && !dec_i && !sub_i) |=>
      ({flag_c_o, result_o} == ({1'b0, $past(acc_i)} + {1'b0, $past(opnd_i)}
                                + {{W{1'b0}}, $past(carry_i)})));

  // R3
  bin_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && !dec_i) |=> (flag_z_o == (result_o == '0)));

  // R8
  neg_from_result_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_i |=> (flag_n_o == result_o[W-1]));

  // R6
  dec_digit_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && dec_i && (&in_ok)) |=> (&out_ok));
endmodule

// File: tb/bcd_addsub_tb_top.sv
module bcd_addsub_tb_top;
  localparam int DIGITS = 2;
  localparam int W = 4 * DIGITS;
  localparam logic [W-1:0] NINES = {DIGITS{4'h9}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [W-1:0] acc_i = '0, opnd_i = '0;
  logic carry_i = 1'b0, dec_i = 1'b0, sub_i = 1'b0;
  logic [W-1:0] result_o;
  logic flag_n_o, flag_z_o, flag_c_o, flag_v_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_addsub #(.DIGITS(DIGITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
    .acc_i(acc_i), .opnd_i(opnd_i), .carry_i(carry_i),
    .dec_i(dec_i), .sub_i(sub_i), .result_o(result_o),
    .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
    .flag_c_o(flag_c_o), .flag_v_o(flag_v_o)
  );

  // returns {result, n, z, c, v}
  function automatic logic [W+3:0] ref_calc(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic ci, input logic dm, input logic sb);
    logic [W-1:0] d, r;
    logic [W:0]   bs;
    logic n, z, c, v;
    int carry, s, top_raw;
    if (!dm) begin
      d  = sb ? ~b : b;
      bs = {1'b0, a} + {1'b0, d} + {{W{1'b0}}, ci};
      r  = bs[W-1:0];
      c  = bs[W];
      n  = r[W-1];
      z  = (r == '0);
      v  = (a[W-1] == d[W-1]) && (r[W-1] != a[W-1]);
    end else begin
      d = sb ? (NINES - b) : b;
      carry = int'(ci);
      top_raw = 0;
      r = '0;
      for (int i = 0; i < DIGITS; i++) begin
        s = int'(a[4*i +: 4]) + int'(d[4*i +: 4]) + carry;
        if (i == DIGITS - 1) top_raw = s;
        if (s > 9) s = s + 6;
        carry = (s > 15) ? 1 : 0;
        r[4*i +: 4] = s[3:0];
      end
      bs = {1'b0, a} + {1'b0, d} + {{W{1'b0}}, ci};
      z  = (bs[W-1:0] == '0);
      c  = carry[0];
      n  = r[W-1];
      v  = (a[W-1] == d[W-1]) && (a[W-1] != top_raw[3]);
    end
    return {r, n, z, c, v};
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic ci, input logic dm, input logic sb);
    logic [W+3:0] e;
    e = ref_calc(a, b, ci, dm, sb);
    @(negedge clk);
    acc_i = a; opnd_i = b; carry_i = ci; dec_i = dm; sub_i = sb; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    if (!dm && !sb) begin
      check("R3 result", result_o, e[W+3:4]);
      check("R3 carry", W'(flag_c_o), W'(e[1]));
      check("R3 neg", W'(flag_n_o), W'(e[3]));
      check("R3 zero", W'(flag_z_o), W'(e[2]));
      check("R4 ovf", W'(flag_v_o), W'(e[0]));
    end else if (!dm) begin
      check("R5 result", result_o, e[W+3:4]);
      check("R5 carry", W'(flag_c_o), W'(e[1]));
      check("R5 nz", W'({flag_n_o, flag_z_o}), W'(e[3:2]));
      check("R4 ovf", W'(flag_v_o), W'(e[0]));
    end else begin
      check(sb ? "R10 result" : "R6 result", result_o, e[W+3:4]);
      check(sb ? "R10 carry" : "R6 carry", W'(flag_c_o), W'(e[1]));
      check("R7 zero", W'(flag_z_o), W'(e[2]));
      check("R8 neg", W'(flag_n_o), W'(e[3]));
      check("R9 ovf", W'(flag_v_o), W'(e[0]));
    end
  endtask

  function automatic logic [W-1:0] rand_bcd();
    logic [W-1:0] x;
    for (int i = 0; i < DIGITS; i++) x[4*i +: 4] = 4'($urandom_range(9));
    return x;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] hold_r;
    logic [3:0]   hold_f;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset result", result_o, '0);
    check("R1 reset flags", W'({flag_n_o, flag_z_o, flag_c_o, flag_v_o}), '0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 after release", W'({result_o, flag_n_o, flag_z_o, flag_c_o, flag_v_o}), '0);

    // directed binary corners
    run_op(8'hFF, 8'h01, 1'b0, 1'b0, 1'b0);
    run_op(8'h7F, 8'h01, 1'b0, 1'b0, 1'b0);
    run_op(8'h80, 8'h80, 1'b0, 1'b0, 1'b0);
    run_op(8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
    run_op(8'h50, 8'hF0, 1'b1, 1'b0, 1'b1);
    run_op(8'h00, 8'h01, 1'b1, 1'b0, 1'b1);
    run_op(8'h80, 8'h01, 1'b1, 1'b0, 1'b1);
    // directed decimal corners
    run_op(8'h58, 8'h46, 1'b1, 1'b1, 1'b0);
    run_op(8'h99, 8'h01, 1'b0, 1'b1, 1'b0);
    run_op(8'h99, 8'h99, 1'b1, 1'b1, 1'b0);
    run_op(8'h79, 8'h00, 1'b1, 1'b1, 1'b0);
    run_op(8'h12, 8'h01, 1'b1, 1'b1, 1'b1);
    run_op(8'h00, 8'h01, 1'b1, 1'b1, 1'b1);
    run_op(8'h46, 8'h12, 1'b0, 1'b1, 1'b1);
    run_op(8'hFA, 8'hCB, 1'b1, 1'b1, 1'b0);

    // R2: inputs change with no strobe, outputs must hold
    hold_r = result_o;
    hold_f = {flag_n_o, flag_z_o, flag_c_o, flag_v_o};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      acc_i = W'($urandom); opnd_i = W'($urandom);
      carry_i = 1'($urandom); dec_i = 1'($urandom); sub_i = 1'($urandom);
    end
    @(negedge clk);
    check("R2 hold result", result_o, hold_r);
    check("R2 hold flags", W'({flag_n_o, flag_z_o, flag_c_o, flag_v_o}), W'(hold_f));

    for (int k = 0; k < 4000; k++) begin
      logic dm;
      dm = 1'($urandom);
      if (dm && ($urandom_range(3) != 0))
        run_op(rand_bcd(), rand_bcd(), 1'($urandom), 1'b1, 1'($urandom));
      else
        run_op(W'($urandom), W'($urandom), 1'($urandom), dm, 1'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule